// File: doc/BRIEF.md
# Synchronous Serial Transceiver

This block sends and receives bytes over a three-wire synchronous link: a shift clock, a transmit data line and a receive data line. Transmitter and receiver share one shift clock. Each direction has a one-byte holding buffer in front of its shift register, so software can queue the next byte while the current one is shifting. The shift clock comes from an on-chip divider, or the clock master can be on the far side and drive an external clock into the block. A receive-ready output, active low, tells an external clock master that a byte can be accepted.

Software uses four byte registers on a simple register bus. A write to the data register queues a byte for transmission. When the shift clock is generated on chip, that write also starts the transfer. A read of the data register returns the last received byte. Status flags report an empty transmit buffer, a finished shift, a full receive buffer and an overrun. Two level interrupt requests are derived from these flags. The transmit interrupt source can be selected.

Top module: `sync_serial_unit`

## Requirements
- R1: Register addresses are 0 = data, 1 = status, 2 = control and 3 = divider value n. Status bit 0 is tx_empty, bit 1 shift_done, bit 2 rx_full and bit 3 overrun. Control bit 0 enables the block, bit 1 enables transmit, bit 2 enables receive, bit 3 selects the external clock, bit 4 selects the slow count source, bit 5 is the transmit interrupt select and bit 6 enables the ready output. After reset, status reads 0x03, control reads 0, sclk_o = 1, txd_o = 1 and rx_ready_no = 1.
- R2: Frames are 8 bits, least significant bit first. txd_o changes only on a falling shift-clock edge. rxd_i is sampled on the rising edge.
- R3: With the internal clock, a write to the data register starts a transfer. Each half period of sclk_o lasts P*(n+1) system cycles, with P = 4 when control bit 4 is 0 and P = 16 when it is 1. The full range is 1/8 to 1/8192 of the system clock.
- R4: tx_empty is cleared by a data write and set when the buffered byte moves into the shift register. shift_done is cleared at that move. shift_done is set after the last bit only when no byte is waiting.
- R5: A byte written while a shift is in progress follows the previous byte with no gap: every sclk_o half period stays equal across the byte boundary.
- R6: rx_full is set once 8 bits have been received, and the byte goes to the receive buffer. A data read returns that byte and clears rx_full. rx_irq_o = enable AND rx_full.
- R7: A byte that completes while rx_full = 1 sets overrun and replaces the buffer contents. overrun is cleared only by a write to the status register; a data read leaves it set.
- R8: tx_irq_o = enable AND (shift_done if control bit 5 is 1, else tx_empty).
- R9: With the external clock selected, sclk_i is synchronised and its edges drive the shift. sclk_o stays high, and a data write alone starts nothing.
- R10: rx_ready_no is low when enable, receive enable and ready enable are all 1, rx_full = 0 and no byte is in progress. It goes high on the first clock edge of a byte.
- R11: While enable is 0, no transfer runs and sclk_o stays high, even after a data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (data read clears rx_full) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational on the address |
| sclk_i | input | 1 | External shift clock |
| sclk_o | output | 1 | Internal shift clock, idles high |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |
| rx_ready_no | output | 1 | Receive ready to clock master, active low |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |

## Verification
A wrong bit counter or shift register shows up as a wrong byte, either on txd_o or in the data register. This appears at the end of the very frame in which it occurs, because the bench rebuilds every transmitted byte and compares it with what was queued. A divider or chaining fault changes the sclk_o half period, and the bench measures every half period. Flag faults show up within one frame: the status register, the interrupt lines or the ready output disagree with the sequence of loads and completions the stimulus has caused.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  typedef struct packed {
    logic rsvd;
    logic rdy_en;
    logic irq_sel;
    logic slow_src;
    logic ext_clk;
    logic rx_en;
    logic tx_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/ssu_ctrl_regs.sv
module ssu_ctrl_regs
  import ssu_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output ctrl_t            ctrl_o,
  output logic [DIV_W-1:0] div_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      div_o  <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_CTRL) ctrl_o <= ctrl_t'(wdata_i);
      if (addr_i == ADDR_DIV)  div_o  <= wdata_i[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/ssu_baud_gen.sv
module ssu_baud_gen #(
  parameter int DIV_W    = 8,
  parameter int PRE_FAST = 4,
  parameter int PRE_SLOW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             slow_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             half_tick_o
);
  localparam int PW = $clog2(PRE_SLOW);
  localparam logic [PW-1:0] FAST_LAST = PW'(PRE_FAST - 1);
  localparam logic [PW-1:0] SLOW_LAST = PW'(PRE_SLOW - 1);

  logic [PW-1:0]    pre_cnt_q;
  logic [DIV_W-1:0] div_cnt_q;
  logic             pre_last;

  assign pre_last    = pre_cnt_q == (slow_i ? SLOW_LAST : FAST_LAST);
  assign half_tick_o = run_i & pre_last & (div_cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (!run_i) begin
      pre_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (pre_last) begin
      pre_cnt_q <= '0;
      div_cnt_q <= (div_cnt_q == div_i) ? '0 : div_cnt_q + 1'b1;
    end else begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssu_ext_sync.sv
module ssu_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-1:0], sclk_i};
  end

  assign fall_o = sync_q[STAGES] & ~sync_q[STAGES-1];
  assign rise_o = ~sync_q[STAGES] & sync_q[STAGES-1];
endmodule

// File: rtl/ssu_shift_core.sv
module ssu_shift_core
  import ssu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic          half_tick_i,
  input  logic          ext_fall_i,
  input  logic          ext_rise_i,
  input  logic          tx_wr_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          rx_rd_i,
  input  logic          stat_wr_i,
  input  logic          rxd_i,
  output logic          run_o,
  output logic          sclk_o,
  output logic          txd_o,
  output logic          rx_ready_no,
  output logic          tx_empty_o,
  output logic          shift_done_o,
  output logic          rx_full_o,
  output logic          overrun_o,
  output logic [DW-1:0] rx_buf_o
);
  localparam int CNT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DW - 1);

  logic             sclk_q, run_q, in_byte_q, have_tx_q, txd_q;
  logic             tx_empty_q, shift_done_q, rx_full_q, overrun_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0]    tx_buf_q, tx_sr_q, rx_sr_q, rx_buf_q;
  logic             int_mode, fall_ev, rise_ev, last_bit, pend;
  logic [DW-1:0]    rx_next;

  assign int_mode = ctrl_i.en & ~ctrl_i.ext_clk;
  assign fall_ev  = ctrl_i.en & (ctrl_i.ext_clk ? ext_fall_i : (half_tick_i & run_q & sclk_q));
  assign rise_ev  = ctrl_i.en & (ctrl_i.ext_clk ? ext_rise_i : (half_tick_i & run_q & ~sclk_q));
  assign last_bit = rise_ev & (cnt_q == LAST_IDX);
  assign pend     = ~tx_empty_q | tx_wr_i;
  assign rx_next  = {rxd_i, rx_sr_q[DW-1:1]};

  // shift clock and run control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      run_q  <= 1'b0;
    end else if (!int_mode) begin
      sclk_q <= 1'b1;
      run_q  <= 1'b0;
    end else begin
      if (half_tick_i && run_q) sclk_q <= ~sclk_q;
      if (!run_q && !tx_empty_q) run_q <= 1'b1;
      else if (last_bit && !pend) run_q <= 1'b0;
    end
  end

  // datapath and flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      in_byte_q    <= 1'b0;
      have_tx_q    <= 1'b0;
      txd_q        <= 1'b1;
      tx_buf_q     <= '0;
      tx_sr_q      <= '0;
      rx_sr_q      <= '0;
      rx_buf_q     <= '0;
      tx_empty_q   <= 1'b1;
      shift_done_q <= 1'b1;
      rx_full_q    <= 1'b0;
      overrun_q    <= 1'b0;
    end else begin
      if (!ctrl_i.en) begin
        cnt_q     <= '0;
        in_byte_q <= 1'b0;
        have_tx_q <= 1'b0;
      end
      if (rx_rd_i)   rx_full_q <= 1'b0;
      if (stat_wr_i) overrun_q <= 1'b0;

      if (fall_ev) begin
        if (cnt_q == '0) begin
          in_byte_q <= 1'b1;
          if (!tx_empty_q) begin
            tx_sr_q      <= tx_buf_q >> 1;
            txd_q        <= ctrl_i.tx_en ? tx_buf_q[0] : 1'b1;
            tx_empty_q   <= 1'b1;
            shift_done_q <= 1'b0;
            have_tx_q    <= 1'b1;
          end else begin
            txd_q     <= 1'b1;
            have_tx_q <= 1'b0;
          end
        end else begin
          txd_q   <= (ctrl_i.tx_en & have_tx_q) ? tx_sr_q[0] : 1'b1;
          tx_sr_q <= tx_sr_q >> 1;
        end
      end

      if (rise_ev) begin
        rx_sr_q <= rx_next;
        cnt_q   <= cnt_q + 1'b1;
        if (last_bit) begin
          cnt_q     <= '0;
          in_byte_q <= 1'b0;
          if (have_tx_q && !pend) shift_done_q <= 1'b1;
          if (ctrl_i.rx_en) begin
            rx_buf_q  <= rx_next;
            rx_full_q <= 1'b1;
            if (rx_full_q && !rx_rd_i) overrun_q <= 1'b1;
          end
        end
      end

      if (tx_wr_i) begin
        tx_buf_q   <= tx_data_i;
        tx_empty_q <= 1'b0;
      end
    end
  end

  assign run_o        = run_q;
  assign sclk_o       = sclk_q;
  assign txd_o        = txd_q;
  assign rx_ready_no  = ~(ctrl_i.en & ctrl_i.rx_en & ctrl_i.rdy_en & ~rx_full_q & ~in_byte_q);
  assign tx_empty_o   = tx_empty_q;
  assign shift_done_o = shift_done_q;
  assign rx_full_o    = rx_full_q;
  assign overrun_o    = overrun_q;
  assign rx_buf_o     = rx_buf_q;
endmodule

// File: rtl/sync_serial_unit.sv
module sync_serial_unit
  import ssu_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int PRE_FAST = 4,
  parameter int PRE_SLOW = 16,
  parameter int SYNC_STG = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       sclk_i,
  output logic       sclk_o,
  output logic       txd_o,
  input  logic       rxd_i,
  output logic       rx_ready_no,
  output logic       tx_irq_o,
  output logic       rx_irq_o
);
  localparam int DW = 8;

  ctrl_t            ctrl;
  logic [DIV_W-1:0] div_n;
  logic             run, half_tick, ext_fall, ext_rise;
  logic             tx_empty, shift_done, rx_full, overrun;
  logic [DW-1:0]    rx_buf;

  ssu_ctrl_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl), .div_o(div_n)
  );

  ssu_baud_gen #(.DIV_W(DIV_W), .PRE_FAST(PRE_FAST), .PRE_SLOW(PRE_SLOW)) u_baud (
    .clk_i, .rst_ni,
    .run_i(run), .slow_i(ctrl.slow_src), .div_i(div_n), .half_tick_o(half_tick)
  );

  ssu_ext_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .fall_o(ext_fall), .rise_o(ext_rise)
  );

  ssu_shift_core #(.DW(DW)) u_core (
    .clk_i, .rst_ni,
    .ctrl_i(ctrl),
    .half_tick_i(half_tick), .ext_fall_i(ext_fall), .ext_rise_i(ext_rise),
    .tx_wr_i(reg_wr_i && reg_addr_i == ADDR_DATA), .tx_data_i(reg_wdata_i),
    .rx_rd_i(reg_rd_i && reg_addr_i == ADDR_DATA),
    .stat_wr_i(reg_wr_i && reg_addr_i == ADDR_STAT),
    .rxd_i,
    .run_o(run), .sclk_o, .txd_o, .rx_ready_no,
    .tx_empty_o(tx_empty), .shift_done_o(shift_done),
    .rx_full_o(rx_full), .overrun_o(overrun), .rx_buf_o(rx_buf)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_DATA: reg_rdata_o = rx_buf;
      ADDR_STAT: reg_rdata_o = {4'b0, overrun, rx_full, shift_done, tx_empty};
      ADDR_CTRL: reg_rdata_o = ctrl;
      default:   reg_rdata_o = 8'(div_n);
    endcase
  end

  assign tx_irq_o = ctrl.en & (ctrl.irq_sel ? shift_done : tx_empty);
  assign rx_irq_o = ctrl.en & rx_full;
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker
  import ssu_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input ctrl_t ctrl,
  input logic  sclk_o,
  input logic  txd_o,
  input logic  rx_ready_no,
  input logic  rx_irq_o,
  input logic  tx_empty,
  input logic  shift_done,
  input logic  rx_full,
  input logic  overrun
);
  AST_SCLK_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.en |=> sclk_o); // R11

  AST_TXD_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.ext_clk && !$past(ctrl.ext_clk) && !$stable(txd_o)) |-> $fell(sclk_o)); // R2

  AST_EMPTY_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.ext_clk && $rose(tx_empty)) |-> $fell(sclk_o)); // R4

  AST_DONE_NOTHING_QUEUED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shift_done) |-> tx_empty); // R4

  AST_OVERRUN_AFTER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun) |-> $past(rx_full)); // R7

  AST_READY_ONLY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_no |-> !rx_full); // R10

  AST_RX_IRQ_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_full); // R6
endmodule

bind sync_serial_unit ssu_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl(ctrl), .sclk_o(sclk_o), .txd_o(txd_o),
  .rx_ready_no(rx_ready_no), .rx_irq_o(rx_irq_o), .tx_empty(tx_empty),
  .shift_done(shift_done), .rx_full(rx_full), .overrun(overrun)
);

// File: tb/sync_serial_unit_bench.sv
`timescale 1ns/1ps
module sync_serial_unit_bench;
  localparam logic [7:0] C_EN = 8'h01, C_TX = 8'h02, C_RX = 8'h04, C_EXT = 8'h08;
  localparam logic [7:0] C_SLOW = 8'h10, C_ISEL = 8'h20, C_RDY = 8'h40;
  localparam logic [7:0] C_BASE = C_EN | C_TX | C_RX | C_RDY;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, sclk_in = 1'b1, rxd = 1'b1;
  logic [7:0] wdata = '0, rdata;
  logic sclk_out, txd, rdy_n, tx_irq, rx_irq;

  always #10 clk = ~clk;

  sync_serial_unit u_sync_serial_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sclk_i(sclk_in), .sclk_o(sclk_out),
    .txd_o(txd), .rxd_i(rxd), .rx_ready_no(rdy_n), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0, mon_on = 1'b0, ext_tb = 1'b0;
  logic [7:0] tx_exp_q[$], rx_pat_q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // line clock as seen by the far end
  logic line_clk;
  assign line_clk = ext_tb ? sclk_in : sclk_out;

  // monitor: rebuild TxD bytes on rising edges, LSB first
  logic [7:0] mon_sr = '0;
  int mon_n = 0;
  always @(posedge line_clk) if (mon_on) begin
    mon_sr = {txd, mon_sr[7:1]};
    mon_n++;
    if (mon_n == 8) begin
      mon_n = 0;
      if (tx_exp_q.size() == 0) chk(1'b0, "R2", "unexpected txd byte", mon_sr, 0);
      else begin
        logic [7:0] e;
        e = tx_exp_q.pop_front();
        chk(mon_sr == e, "R2", "txd byte", mon_sr, e);
      end
    end
  end

  // far-end sender: new bit on each falling edge
  logic [7:0] sl_byte = 8'hFF;
  int sl_n = 0;
  always @(negedge line_clk) if (mon_on) begin
    if (sl_n == 0) sl_byte = (rx_pat_q.size() != 0) ? rx_pat_q.pop_front() : 8'hFF;
    rxd = sl_byte[sl_n];
    sl_n = (sl_n + 1) % 8;
  end

  // sclk_o half-period measurement
  int hc = 0, hmin = 0, hmax = 0, edges = 0;
  bit armed = 1'b0, meas_clr = 1'b0;
  logic sclk_prev = 1'b1;
  always begin
    @(posedge clk);
    #2;
    if (meas_clr) begin
      armed = 1'b0; hmin = 1 << 30; hmax = 0; edges = 0; meas_clr = 1'b0;
    end
    hc++;
    if (sclk_out !== sclk_prev) begin
      if (armed) begin
        if (hc < hmin) hmin = hc;
        if (hc > hmax) hmax = hc;
        edges++;
      end
      hc = 0;
      armed = 1'b1;
    end
    sclk_prev = sclk_out;
  end

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_stat(input logic [7:0] mask, input logic [7:0] val, input string req);
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      reg_rd(2'd1, s);
      if ((s & mask) == val) return;
    end
    chk(1'b0, req, "status poll timeout", s, val);
  endtask

  // driver: queue expected TxD byte and far-end byte, then write data register
  task automatic send(input logic [7:0] tx, input logic [7:0] rx_pat);
    tx_exp_q.push_back(tx);
    rx_pat_q.push_back(rx_pat);
    reg_wr(2'd0, tx);
  endtask

  task automatic clear_meas();
    @(negedge clk);
    meas_clr = 1'b1;
    @(negedge clk);
  endtask

  task automatic ext_pulse();
    repeat (10) @(negedge clk);
    sclk_in = 1'b0;
    repeat (10) @(negedge clk);
    sclk_in = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(2'd1, s);  chk(s == 8'h03, "R1", "status after reset", s, 8'h03);
    reg_rd(2'd2, s);  chk(s == 8'h00, "R1", "control after reset", s, 8'h00);
    chk(sclk_out == 1'b1 && txd == 1'b1, "R1", "line idle", {sclk_out, txd}, 2'b11);
    chk(rdy_n == 1'b1, "R1", "ready idle", rdy_n, 1);

    reg_wr(2'd3, 8'd0);
    reg_wr(2'd2, C_BASE);
    chk(rdy_n == 1'b0, "R10", "ready asserted", rdy_n, 0);
    chk(tx_irq == 1'b1, "R8", "tx irq on empty", tx_irq, 1);

    // single transfer
    mon_on = 1'b1;
    clear_meas();
    send(8'hA5, 8'h3C);
    repeat (12) @(negedge clk);
    chk(rdy_n == 1'b1, "R10", "ready released in byte", rdy_n, 1);
    wait_stat(8'h06, 8'h06, "R6");
    reg_rd(2'd1, s);  chk(s == 8'h07, "R4", "status after byte", s, 8'h07);
    chk(rx_irq == 1'b1, "R6", "rx irq", rx_irq, 1);
    reg_rd(2'd0, s);  chk(s == 8'h3C, "R6", "rx byte", s, 8'h3C);
    reg_rd(2'd1, s);  chk(s == 8'h03, "R6", "full cleared by read", s, 8'h03);
    chk(rdy_n == 1'b0, "R10", "ready again", rdy_n, 0);
    chk(hmin == 4 && hmax == 4, "R3", "half period n=0", hmax, 4);

    // chained bytes
    clear_meas();
    send(8'h11, 8'h81);
    wait_stat(8'h01, 8'h01, "R4");
    reg_rd(2'd1, s);  chk(s[1] == 1'b0, "R4", "shift_done cleared at load", s[1], 0);
    send(8'h22, 8'h7E);
    reg_rd(2'd1, s);  chk(s[0] == 1'b0, "R4", "empty cleared by write", s[0], 0);
    wait_stat(8'h04, 8'h04, "R6");
    reg_rd(2'd0, s);  chk(s == 8'h81, "R6", "chained rx byte 1", s, 8'h81);
    wait_stat(8'h06, 8'h06, "R5");
    reg_rd(2'd0, s);  chk(s == 8'h7E, "R6", "chained rx byte 2", s, 8'h7E);
    chk(hmin == 4 && hmax == 4, "R5", "no gap max half", hmax, 4);
    chk(edges == 31, "R5", "edge count", edges, 31);

    // interrupt select
    reg_wr(2'd2, C_BASE | C_ISEL);
    chk(tx_irq == 1'b1, "R8", "irq on shift_done idle", tx_irq, 1);
    send(8'h5A, 8'h00);
    repeat (12) @(negedge clk);
    chk(tx_irq == 1'b0, "R8", "irq low while shifting", tx_irq, 0);
    wait_stat(8'h02, 8'h02, "R8");
    chk(tx_irq == 1'b1, "R8", "irq after shift", tx_irq, 1);
    wait_stat(8'h04, 8'h04, "R6");
    reg_rd(2'd0, s);  chk(s == 8'h00, "R6", "rx zero byte", s, 8'h00);

    // overrun
    reg_wr(2'd2, C_BASE);
    send(8'hC3, 8'h12);
    wait_stat(8'h06, 8'h06, "R7");
    send(8'h3C, 8'h34);
    wait_stat(8'h08, 8'h08, "R7");
    reg_rd(2'd1, s);  chk(s == 8'h0F, "R7", "overrun status", s, 8'h0F);
    reg_rd(2'd0, s);  chk(s == 8'h34, "R7", "buffer replaced", s, 8'h34);
    reg_rd(2'd1, s);  chk(s == 8'h0B, "R7", "overrun survives read", s, 8'h0B);
    reg_wr(2'd1, 8'h00);
    reg_rd(2'd1, s);  chk(s == 8'h03, "R7", "overrun cleared", s, 8'h03);

    // slow source and divider
    reg_wr(2'd3, 8'd2);
    reg_wr(2'd2, C_BASE | C_SLOW);
    clear_meas();
    send(8'h96, 8'h69);
    wait_stat(8'h06, 8'h06, "R3");
    chk(hmin == 48 && hmax == 48, "R3", "half period slow n=2", hmax, 48);
    chk(edges == 15, "R3", "slow edge count", edges, 15);
    reg_rd(2'd0, s);  chk(s == 8'h69, "R6", "rx slow byte", s, 8'h69);

    // external clock
    reg_wr(2'd2, C_BASE | C_EXT);
    ext_tb = 1'b1;
    clear_meas();
    send(8'hE1, 8'h1E);
    repeat (20) @(negedge clk);
    reg_rd(2'd1, s);  chk(s[0] == 1'b0, "R9", "no start without clock", s[0], 0);
    chk(rdy_n == 1'b0, "R10", "ready before ext clock", rdy_n, 0);
    repeat (10) @(negedge clk);
    sclk_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(rdy_n == 1'b1, "R10", "ready off after first edge", rdy_n, 1);
    repeat (4) @(negedge clk);
    sclk_in = 1'b1;
    for (int b = 1; b < 8; b++) ext_pulse();
    repeat (6) @(negedge clk);
    chk(edges == 0 && sclk_out == 1'b1, "R9", "sclk_o held high", edges, 0);
    reg_rd(2'd1, s);  chk(s == 8'h07, "R9", "ext status", s, 8'h07);
    reg_rd(2'd0, s);  chk(s == 8'h1E, "R9", "ext rx byte", s, 8'h1E);

    // disabled block
    reg_wr(2'd2, 8'h00);
    ext_tb = 1'b0;
    reg_wr(2'd3, 8'd0);
    clear_meas();
    reg_wr(2'd0, 8'h44);
    repeat (60) @(negedge clk);
    chk(edges == 0 && sclk_out == 1'b1, "R11", "no clock when disabled", edges, 0);
    chk(tx_irq == 1'b0 && rx_irq == 1'b0, "R11", "irqs off when disabled", {tx_irq, rx_irq}, 0);
    chk(rdy_n == 1'b1, "R11", "ready off when disabled", rdy_n, 1);

    chk(tx_exp_q.size() == 0, "R2", "bytes left unsent", tx_exp_q.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule